// File: doc/BRIEF.md
# Bus-attached seconds counter with alarm

This block is a real-time clock peripheral for a slow control bus. A prescaler divides the system clock into a one-cycle tick per second, and each tick advances a 32-bit seconds count. The count wraps around modulo 2^32. Software can overwrite the count at any time, and the count then keeps running from the value written. Software can also program a 32-bit alarm value. When the running count steps onto that value, a sticky pending bit is set. The pending bit is gated by an enable bit to form one level-sensitive interrupt line. It stays set until software writes a one to a dedicated clear register. A set of read-only identification bytes sits at the top of the 4 KB register window.

Access follows a two-phase APB-style protocol: a setup cycle, then an enable cycle. A small bus state machine tracks the protocol and has three states. `BUS_IDLE` means no transfer is pending. `BUS_SETUP` means an address has been presented and the enable phase is awaited. `BUS_DONE` means a transfer completed on the previous edge. The transitions are:

- IDLE→SETUP on select without enable.
- SETUP→DONE on select with enable. The transfer happens on this edge, and write data is committed at it.
- SETUP→SETUP while the setup phase is held.
- SETUP→IDLE when select is withdrawn (an abandoned transfer).
- DONE→SETUP on a back-to-back setup.
- DONE→IDLE otherwise.

Read data and the error flag are valid during the enable cycle.

Top module: `sec_rtc`

## Requirements
- R1: After reset the count, alarm value, last-loaded value, interrupt enable and pending bit all read 0, and `irq` is 0.
- R2: The count rises by exactly 1 once every `TICK_DIV` clock cycles. A write to the load register restarts the prescaler, so the first increment after a load lands `TICK_DIV` edges after the edge that committed the load.
- R3: A write to offset 0x08 replaces the running count with the written value, and a read of 0x08 returns the last value written there. A read of 0x00 returns the running count, which goes from 0xFFFFFFFF to 0x00000000.
- R4: The pending bit (bit 0 of 0x14) is set on the edge where a tick makes the count equal to the alarm value at 0x04. This includes an alarm below the current count, reached after the count wraps. A load whose value equals the alarm does not set it.
- R5: `irq` equals pending AND enable, where the enable is bit 0 of 0x10. A read of 0x18 returns that same AND in bit 0.
- R6: Writing 1 in bit 0 of 0x1C clears the pending bit, and writing 0 there leaves it unchanged. If an alarm hit occurs on the same edge as the clear, the pending bit stays set.
- R7: Offset 0x0C always reads 1. A write to it has no effect and no error.
- R8: Reads at 0xFE0 + 4·k for k = 0..7 return, in order, 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Each of the following returns read data 0 and raises `pslverr`: a read of 0x1C, any access to an unmapped or unaligned offset, and a write to 0x00, 0x14, 0x18 or the identification bytes. Writes to read-only offsets leave all state unchanged.
- R10: A register changes only when a setup cycle is followed by an enable cycle. An abandoned setup phase writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Enable phase of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the enable cycle |
| pslverr | output | 1 | Error response, valid in the enable cycle |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The assertions assume that transfers follow the two-phase order: select is raised without enable, and enable is raised one cycle later with address, direction and data held steady. The bench uses only tasks that drive exactly that shape on the falling clock edge. The one exception is a deliberate abandoned setup phase, which the bus state machine must tolerate. The prescaler is shortened to 8 cycles in the bench. Every timing-sensitive case is entered by a fresh load, so that the tick phase is known and no alarm hit falls inside a window where the bench expects none.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;

    // Bus protocol tracker states
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_SETUP = 2'd1,
        BUS_DONE  = 2'd2
    } bus_state_t;

    // Decoded register target
    typedef enum logic [3:0] {
        RG_COUNT,
        RG_ALARM,
        RG_LOAD,
        RG_CTRL,
        RG_ENABLE,
        RG_PEND,
        RG_GATED,
        RG_CLEAR,
        RG_IDENT,
        RG_NONE
    } reg_sel_t;

    // Word index inside the low page (address bits [4:2])
    localparam logic [2:0] WIX_COUNT  = 3'd0;
    localparam logic [2:0] WIX_ALARM  = 3'd1;
    localparam logic [2:0] WIX_LOAD   = 3'd2;
    localparam logic [2:0] WIX_CTRL   = 3'd3;
    localparam logic [2:0] WIX_ENABLE = 3'd4;
    localparam logic [2:0] WIX_PEND   = 3'd5;
    localparam logic [2:0] WIX_GATED  = 3'd6;
    localparam logic [2:0] WIX_CLEAR  = 3'd7;

    localparam int IDENT_COUNT = 8;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h31;
            3'd1: b = 8'h10;
            3'd2: b = 8'h14;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            3'd7: b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
    parameter int unsigned TICK_DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_spaced
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick) else $error("tick on consecutive cycles"); // R2
            AST_RESTART_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick) else $error("tick right after restart"); // R2
        end
    endgenerate

endmodule

// File: rtl/sec_rtc_core.sv
module sec_rtc_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_we,
    input  logic             alarm_we,
    input  logic             enable_we,
    input  logic             clear_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] loaded,
    output logic             enable,
    output logic             pending
);
    logic [CNT_W-1:0] count_step;
    logic             alarm_hit;

    assign count_step = count + 1'b1;
    // Compare the value the count is about to take, so the pending bit
    // rises on the same edge the count lands on the alarm value.
    assign alarm_hit  = tick && !load_we && (count_step == alarm);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_we) begin
            count <= wdata;
        end else if (tick) begin
            count <= count_step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded <= '0;
        end else if (load_we) begin
            loaded <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= '0;
        end else if (alarm_we) begin
            alarm <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
        end else if (enable_we) begin
            enable <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (alarm_hit) begin
            pending <= 1'b1;
        end else if (clear_we && wdata[0]) begin
            pending <= 1'b0;
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count == $past(wdata)) && (loaded == $past(wdata))) else $error("load lost"); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_we) |=> count == $past(count) + 1'b1) else $error("bad step"); // R2
    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_we) |=> $stable(count)) else $error("count moved without tick"); // R2
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clear_we) |=> pending) else $error("pending dropped"); // R6
    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> (count == alarm) && !$past(load_we)) else $error("pending without hit"); // R4

endmodule

// File: rtl/sec_rtc_regif.sv
module sec_rtc_regif
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pslverr,
    input  logic [DATA_W-1:0] count,
    input  logic [DATA_W-1:0] alarm,
    input  logic [DATA_W-1:0] loaded,
    input  logic              enable,
    input  logic              pending,
    output logic              load_we,
    output logic              alarm_we,
    output logic              enable_we,
    output logic              clear_we,
    output logic [DATA_W-1:0] wdata
);
    localparam int PAGE_W = ADDR_W - 5;
    localparam logic [PAGE_W-1:0] IDENT_PAGE = '1;
    localparam logic [PAGE_W-1:0] LOW_PAGE   = '0;

    bus_state_t state_q, state_d;
    reg_sel_t   sel;
    logic       xfer;
    logic [DATA_W-1:0] rd_val;
    logic       rd_bad, wr_bad;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and transfer strobe
    always_comb begin
        state_d = state_q;
        xfer    = 1'b0;
        unique case (state_q)
            BUS_IDLE: begin
                if (psel && !penable) state_d = BUS_SETUP;
            end
            BUS_SETUP: begin
                if (!psel) begin
                    state_d = BUS_IDLE;
                end else if (penable) begin
                    state_d = BUS_DONE;
                    xfer    = 1'b1;
                end
            end
            BUS_DONE: begin
                if (psel && !penable) state_d = BUS_SETUP;
                else                  state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // Address decode
    always_comb begin
        sel = RG_NONE;
        if (paddr[1:0] == 2'b00) begin
            if (paddr[ADDR_W-1:5] == IDENT_PAGE) begin
                sel = RG_IDENT;
            end else if (paddr[ADDR_W-1:5] == LOW_PAGE) begin
                unique case (paddr[4:2])
                    WIX_COUNT:  sel = RG_COUNT;
                    WIX_ALARM:  sel = RG_ALARM;
                    WIX_LOAD:   sel = RG_LOAD;
                    WIX_CTRL:   sel = RG_CTRL;
                    WIX_ENABLE: sel = RG_ENABLE;
                    WIX_PEND:   sel = RG_PEND;
                    WIX_GATED:  sel = RG_GATED;
                    WIX_CLEAR:  sel = RG_CLEAR;
                    default:    sel = RG_NONE;
                endcase
            end
        end
    end

    // Read value and error classification per target
    always_comb begin
        rd_val = '0;
        rd_bad = 1'b0;
        wr_bad = 1'b0;
        unique case (sel)
            RG_COUNT:  begin rd_val = count;  wr_bad = 1'b1; end
            RG_ALARM:  rd_val = alarm;
            RG_LOAD:   rd_val = loaded;
            RG_CTRL:   rd_val = DATA_W'(1);
            RG_ENABLE: rd_val = DATA_W'(enable);
            RG_PEND:   begin rd_val = DATA_W'(pending); wr_bad = 1'b1; end
            RG_GATED:  begin rd_val = DATA_W'(pending & enable); wr_bad = 1'b1; end
            RG_CLEAR:  rd_bad = 1'b1;
            RG_IDENT:  begin rd_val = DATA_W'(ident_byte(paddr[4:2])); wr_bad = 1'b1; end
            RG_NONE:   begin rd_bad = 1'b1; wr_bad = 1'b1; end
            default:   begin rd_bad = 1'b1; wr_bad = 1'b1; end
        endcase
    end

    assign prdata    = (xfer && !pwrite && !rd_bad) ? rd_val : '0;
    assign pslverr   = xfer && (pwrite ? wr_bad : rd_bad);
    assign wdata     = pwdata;
    assign load_we   = xfer && pwrite && (sel == RG_LOAD);
    assign alarm_we  = xfer && pwrite && (sel == RG_ALARM);
    assign enable_we = xfer && pwrite && (sel == RG_ENABLE);
    assign clear_we  = xfer && pwrite && (sel == RG_CLEAR);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_we, alarm_we, enable_we, clear_we})) else $error("multiple strobes"); // R10
    AST_NO_WRITE_WITHOUT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_we || alarm_we || enable_we || clear_we) |-> state_q == BUS_SETUP) else $error("write outside access"); // R10
    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pslverr && !pwrite) |-> prdata == '0) else $error("error read not zero"); // R9
    AST_CTRL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !pwrite && sel == RG_CTRL) |-> prdata == DATA_W'(1)) else $error("control not one"); // R7

endmodule

// File: rtl/sec_rtc.sv
module sec_rtc #(
    parameter int unsigned TICK_DIV = 100_000_000,
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pslverr,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] GATED_ADDR = ADDR_W'(24);

    logic              tick;
    logic              load_we, alarm_we, enable_we, clear_we;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] count, alarm, loaded;
    logic              enable, pending;

    sec_rtc_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_we),
        .tick    (tick)
    );

    sec_rtc_core #(.CNT_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_we   (load_we),
        .alarm_we  (alarm_we),
        .enable_we (enable_we),
        .clear_we  (clear_we),
        .wdata     (wdata),
        .count     (count),
        .alarm     (alarm),
        .loaded    (loaded),
        .enable    (enable),
        .pending   (pending)
    );

    sec_rtc_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pslverr   (pslverr),
        .count     (count),
        .alarm     (alarm),
        .loaded    (loaded),
        .enable    (enable),
        .pending   (pending),
        .load_we   (load_we),
        .alarm_we  (alarm_we),
        .enable_we (enable_we),
        .clear_we  (clear_we),
        .wdata     (wdata)
    );

    assign irq = pending & enable;

    AST_IRQ_VS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr == GATED_ADDR && !pslverr) |-> prdata[0] == irq)
        else $error("gated status differs from irq"); // R5

endmodule

// File: tb/sec_rtc_bench.sv
module sec_rtc_bench;
    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pslverr, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sec_rtc #(.TICK_DIV(DIV)) u_sec_rtc (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr), .irq(irq)
    );

    localparam logic [11:0] A_COUNT = 12'h000, A_ALARM = 12'h004, A_LOAD = 12'h008,
                            A_CTRL = 12'h00C, A_EN = 12'h010, A_PEND = 12'h014,
                            A_GATED = 12'h018, A_CLR = 12'h01C;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1 err = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 begin d = prdata; err = pslverr; end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic e;
        bus_wr(a, d, e);
    endtask

    task automatic rd_expect(input string req, input string what, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic e;
        bus_rd(a, d, e);
        chk(req, what, d, exp);
    endtask

    task automatic t_reset();
        rd_expect("R1", "count after reset", A_COUNT, 32'h0);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
        rd_expect("R1", "alarm after reset", A_ALARM, 32'h0);
        rd_expect("R1", "loaded after reset", A_LOAD, 32'h0);
        rd_expect("R1", "enable after reset", A_EN, 32'h0);
        rd_expect("R1", "pending after reset", A_PEND, 32'h0);
    endtask

    task automatic t_tick_timing();
        wr(A_ALARM, 32'h0000_0000);
        wr(A_LOAD, 32'h0000_1000);
        wait_neg(5);
        rd_expect("R2", "count one edge before tick", A_COUNT, 32'h0000_1000);
        wr(A_LOAD, 32'h0000_2000);
        wait_neg(6);
        rd_expect("R2", "count on tick edge", A_COUNT, 32'h0000_2001);
        rd_expect("R3", "load readback", A_LOAD, 32'h0000_2000);
    endtask

    task automatic t_wrap();
        wr(A_ALARM, 32'h0000_0001);
        wr(A_EN, 32'h0);
        wr(A_LOAD, 32'hFFFF_FFFE);
        wait_neg(DIV * 2 + 2);
        rd_expect("R3", "count wraps to zero", A_COUNT, 32'h0000_0000);
        rd_expect("R4", "pending still clear before alarm", A_PEND, 32'h0);
        wait_neg(DIV);
        rd_expect("R4", "alarm below start reached after wrap", A_PEND, 32'h1);
        wr(A_CLR, 32'h1);
    endtask

    task automatic t_alarm_mask();
        wr(A_ALARM, 32'h0000_0502);
        wr(A_EN, 32'h0);
        wr(A_LOAD, 32'h0000_0500);
        wait_neg(DIV * 2 + 4);
        rd_expect("R4", "pending after alarm", A_PEND, 32'h1);
        chk("R5", "irq masked", {31'b0, irq}, 32'h0);
        rd_expect("R5", "gated status masked", A_GATED, 32'h0);
        wr(A_EN, 32'h1);
        chk("R5", "irq enabled", {31'b0, irq}, 32'h1);
        rd_expect("R5", "gated status enabled", A_GATED, 32'h1);
    endtask

    task automatic t_clear();
        wr(A_CLR, 32'hFFFF_FFFE);
        rd_expect("R6", "clear with bit0=0 keeps pending", A_PEND, 32'h1);
        wr(A_CLR, 32'h1);
        rd_expect("R6", "clear drops pending", A_PEND, 32'h0);
        chk("R6", "irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_load_equal();
        wr(A_ALARM, 32'h0000_0777);
        wr(A_LOAD, 32'h0000_0777);
        wait_neg(DIV * 2);
        rd_expect("R4", "load equal to alarm does not set pending", A_PEND, 32'h0);
    endtask

    task automatic t_clear_priority();
        wr(A_ALARM, 32'h0000_0901);
        wr(A_LOAD, 32'h0000_0900);
        wait_neg(5);
        wr(A_CLR, 32'h1);
        rd_expect("R6", "hit beats clear on same edge", A_PEND, 32'h1);
        wr(A_CLR, 32'h1);
    endtask

    task automatic t_ctrl();
        logic e;
        bus_wr(A_CTRL, 32'h0, e);
        chk("R7", "control write no error", {31'b0, e}, 32'h0);
        rd_expect("R7", "control reads one", A_CTRL, 32'h1);
    endtask

    task automatic t_ident();
        logic [7:0] exp_id [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int k = 0; k < 8; k++)
            rd_expect("R8", "ident byte", 12'hFE0 + 12'(4 * k), {24'h0, exp_id[k]});
    endtask

    task automatic t_errors();
        logic [31:0] d;
        logic e;
        bus_rd(A_CLR, d, e);
        chk("R9", "clear read data", d, 32'h0);
        chk("R9", "clear read error", {31'b0, e}, 32'h1);
        bus_rd(12'h020, d, e);
        chk("R9", "unmapped read error", {31'b0, e}, 32'h1);
        chk("R9", "unmapped read data", d, 32'h0);
        bus_rd(12'h005, d, e);
        chk("R9", "unaligned read error", {31'b0, e}, 32'h1);
        bus_rd(12'h800, d, e);
        chk("R9", "far unmapped read error", {31'b0, e}, 32'h1);
        wr(A_LOAD, 32'h0000_0005);
        bus_wr(A_COUNT, 32'hDEAD_0000, e);
        chk("R9", "count write error", {31'b0, e}, 32'h1);
        rd_expect("R9", "count write ignored", A_COUNT, 32'h0000_0005);
        bus_wr(A_PEND, 32'h1, e);
        chk("R9", "pending write error", {31'b0, e}, 32'h1);
        rd_expect("R9", "pending write ignored", A_PEND, 32'h0);
        bus_wr(12'hFE0, 32'h0, e);
        chk("R9", "ident write error", {31'b0, e}, 32'h1);
        rd_expect("R9", "ident write ignored", 12'hFE0, 32'h31);
    endtask

    task automatic t_abandon();
        wr(A_ALARM, 32'h0000_0ABC);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = A_ALARM; pwdata = 32'h1234_5678;
        @(negedge clk);
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        rd_expect("R10", "abandoned setup writes nothing", A_ALARM, 32'h0000_0ABC);
    endtask

    initial begin : watchdog
        int n;
        n = 0;
        while (!done) begin
            @(posedge clk);
            n++;
            if (n > 50000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", n);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        wait_neg(4);
        rst_n = 1'b1;
        t_reset();
        t_tick_timing();
        t_wrap();
        t_alarm_mask();
        t_clear();
        t_load_equal();
        t_clear_priority();
        t_ctrl();
        t_ident();
        t_errors();
        t_abandon();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule